// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block is a small shared word memory that two requesters use at once. Each requester can do four things: a plain read, a plain write, a linked read, or a conditional write. A linked read returns the word and marks that word as reserved for the port that read it. A conditional write commits only if that reservation is still intact. It then reports 1. If the reservation is gone, it reports 0 and leaves memory unchanged. Software builds lock acquisition and other atomic read-modify-write sequences from these pairs. The outcome of a sequence is then decided by the hardware, not by the accidental order of the two requesters' accesses.

Each port holds one reservation: a valid bit and a word address. When a write from one port commits to a word, it removes any reservation the other port holds on that word. A conditional write always consumes the issuing port's own reservation, whether it succeeds or fails. Requests from both ports in the same cycle are ordered with port 0 first. The port 1 request is parked in a one-entry slot and applied on the next cycle, before anything new from port 0. While that slot is occupied, any new port 1 request also waits its turn, so each port's requests complete in issue order and at most one response per port appears per cycle.

Op encoding on `reqOp0`/`reqOp1`: 0 = plain read, 1 = plain write, 2 = linked read, 3 = conditional write. A response appears one cycle after the request is applied.

Top module: `llsc_monitor`

## Requirements
- R1: A plain read (op 0) returns the stored word, and a plain write (op 1) stores its data and responds with data 0.
- R2: A linked read (op 2) returns the stored word and records a reservation on that word for the issuing port.
- R3: A conditional write (op 3) whose port holds a valid reservation on the same word writes its data and responds with the value 1.
- R4: A conditional write from a port with no valid reservation responds with 0 and leaves memory unchanged.
- R5: A committed write (plain or successful conditional) from one port to a word clears the other port's reservation on that word. A write to a different word leaves that reservation intact.
- R6: A conditional write clears the issuing port's own reservation whether it succeeds or fails, so a second conditional write without a new linked read fails.
- R7: A new linked read replaces the port's earlier reservation, so a conditional write to the earlier word fails.
- R8: A conditional write to a word other than the reserved one responds with 0 and does not write.
- R9: A port 0 request responds one cycle after it is issued. A lone port 1 request with no parked request also responds after one cycle. A port 1 request that meets a port 0 request, or arrives while the parked slot is full, is applied one cycle later, after any port 0 request of its own cycle, and responds after two cycles.
- R10: Reset clears both reservations, drops both response valids and zeroes every memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid0 | input | 1 | Port 0 request present |
| reqOp0 | input | 2 | Port 0 operation code |
| reqAddr0 | input | ADDR_W | Port 0 word address |
| reqData0 | input | DATA_W | Port 0 write data |
| reqValid1 | input | 1 | Port 1 request present |
| reqOp1 | input | 2 | Port 1 operation code |
| reqAddr1 | input | ADDR_W | Port 1 word address |
| reqData1 | input | DATA_W | Port 1 write data |
| rspValid0 | output | 1 | Port 0 response present |
| rspData0 | output | DATA_W | Port 0 read data or conditional-write flag |
| rspValid1 | output | 1 | Port 1 response present |
| rspData1 | output | DATA_W | Port 1 read data or conditional-write flag |

## Verification
Directed sequences cover each way a reservation is lost: the other port writing the reserved word, the other port writing a neighbouring word (which must not break it), a replacing linked read, a wrong-address conditional write, and a repeated conditional write. Each shows that the flag tracks the reservation and not merely the address. A same-cycle race puts both ports on one word with linked reads and then conditional writes. Only port 0 may win, which separates correct ordering from reversed or simultaneous application. Random traffic confined to four words mixes all op kinds on both ports with frequent collisions and back-to-back parking. A bench model of the ordering rules predicts every response and its cycle.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LINK  = 2'd2,
    OP_COND  = 2'd3
  } memOp_e;

  // Control-to-datapath strobes: slot 0 always belongs to port 1 (parked),
  // slot 1 carries port 0 or an immediately granted port 1 request.
  typedef struct packed {
    logic firstEn;
    logic secondEn;
    logic secondPort;
  } slotStrobe_t;

endpackage

// File: rtl/llsc_arbiter.sv
module llsc_arbiter
  import llsc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid0,
  input  memOp_e            reqOp0,
  input  logic [ADDR_W-1:0] reqAddr0,
  input  logic [DATA_W-1:0] reqData0,
  input  logic              reqValid1,
  input  memOp_e            reqOp1,
  input  logic [ADDR_W-1:0] reqAddr1,
  input  logic [DATA_W-1:0] reqData1,
  output slotStrobe_t       strobe,
  output memOp_e            firstOp,
  output logic [ADDR_W-1:0] firstAddr,
  output logic [DATA_W-1:0] firstData,
  output memOp_e            secondOp,
  output logic [ADDR_W-1:0] secondAddr,
  output logic [DATA_W-1:0] secondData
);

  logic              parkValid;
  memOp_e            parkOp;
  logic [ADDR_W-1:0] parkAddr;
  logic [DATA_W-1:0] parkData;
  logic              grantNow1;
  logic              parkNext;

  // Port 1 goes straight through only when port 0 is idle and nothing is parked.
  assign grantNow1 = reqValid1 && !reqValid0 && !parkValid;
  assign parkNext  = reqValid1 && !grantNow1;

  always_comb begin
    strobe.firstEn    = parkValid;
    strobe.secondEn   = reqValid0 || grantNow1;
    strobe.secondPort = !reqValid0;
    firstOp           = parkOp;
    firstAddr         = parkAddr;
    firstData         = parkData;
    if (reqValid0) begin
      secondOp   = reqOp0;
      secondAddr = reqAddr0;
      secondData = reqData0;
    end else begin
      secondOp   = reqOp1;
      secondAddr = reqAddr1;
      secondData = reqData1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      parkValid <= 1'b0;
      parkOp    <= OP_LOAD;
      parkAddr  <= '0;
      parkData  <= '0;
    end else begin
      parkValid <= parkNext;
      if (parkNext) begin
        parkOp   <= reqOp1;
        parkAddr <= reqAddr1;
        parkData <= reqData1;
      end
    end
  end

endmodule

// File: rtl/llsc_core.sv
module llsc_core
  import llsc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  slotStrobe_t            strobe,
  input  memOp_e                 firstOp,
  input  logic [ADDR_W-1:0]      firstAddr,
  input  logic [DATA_W-1:0]      firstData,
  input  memOp_e                 secondOp,
  input  logic [ADDR_W-1:0]      secondAddr,
  input  logic [DATA_W-1:0]      secondData,
  output logic [1:0]             rspValid,
  output logic [1:0][DATA_W-1:0] rspData
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PORTS = 2;
  localparam int SLOTS = 2;

  logic [DATA_W-1:0]             mem     [DEPTH];
  logic [DATA_W-1:0]             memNext [DEPTH];
  logic [PORTS-1:0]              resValid, resVNext;
  logic [PORTS-1:0][ADDR_W-1:0]  resAddr, resANext;
  logic [PORTS-1:0]              hitValid;
  logic [PORTS-1:0][DATA_W-1:0]  hitData;

  logic [SLOTS-1:0]              slotEn;
  logic [SLOTS-1:0]              slotPort;
  memOp_e                        slotOp   [SLOTS];
  logic [SLOTS-1:0][ADDR_W-1:0]  slotAddr;
  logic [SLOTS-1:0][DATA_W-1:0]  slotData;

  assign slotEn   = {strobe.secondEn, strobe.firstEn};
  assign slotPort = {strobe.secondPort, 1'b1};
  assign slotOp[0]   = firstOp;
  assign slotOp[1]   = secondOp;
  assign slotAddr = {secondAddr, firstAddr};
  assign slotData = {secondData, firstData};

  // Slots are applied in order so the later one sees the earlier one's effects.
  always_comb begin
    int p;
    logic commit;
    logic keep;
    memNext  = mem;
    resVNext = resValid;
    resANext = resAddr;
    hitValid = '0;
    hitData  = '0;
    for (int s = 0; s < SLOTS; s++) begin
      p      = int'(slotPort[s]);
      commit = 1'b0;
      keep   = 1'b0;
      if (slotEn[s]) begin
        hitValid[p] = 1'b1;
        case (slotOp[s])
          OP_LOAD: hitData[p] = memNext[slotAddr[s]];
          OP_LINK: begin
            hitData[p]  = memNext[slotAddr[s]];
            resVNext[p] = 1'b1;
            resANext[p] = slotAddr[s];
          end
          OP_STORE: begin
            commit     = 1'b1;
            hitData[p] = '0;
          end
          OP_COND: begin
            keep        = resVNext[p] && (resANext[p] == slotAddr[s]);
            commit      = keep;
            resVNext[p] = 1'b0;
            hitData[p]  = DATA_W'(keep);
          end
          default: hitData[p] = '0;
        endcase
        if (commit) begin
          memNext[slotAddr[s]] = slotData[s];
          for (int q = 0; q < PORTS; q++) begin
            if (q != p && resVNext[q] && resANext[q] == slotAddr[s]) begin
              resVNext[q] = 1'b0;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
      resValid <= '0;
      resAddr  <= '0;
    end else begin
      mem      <= memNext;
      resValid <= resVNext;
      resAddr  <= resANext;
    end
  end

  for (genvar g = 0; g < PORTS; g++) begin : gen_rsp
    always_ff @(posedge clk) begin
      if (rst) begin
        rspValid[g] <= 1'b0;
        rspData[g]  <= '0;
      end else begin
        rspValid[g] <= hitValid[g];
        rspData[g]  <= hitData[g];
      end
    end
  end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid0,
  input  logic [1:0]        reqOp0,
  input  logic [ADDR_W-1:0] reqAddr0,
  input  logic [DATA_W-1:0] reqData0,
  input  logic              reqValid1,
  input  logic [1:0]        reqOp1,
  input  logic [ADDR_W-1:0] reqAddr1,
  input  logic [DATA_W-1:0] reqData1,
  output logic              rspValid0,
  output logic [DATA_W-1:0] rspData0,
  output logic              rspValid1,
  output logic [DATA_W-1:0] rspData1
);

  slotStrobe_t            strobe;
  memOp_e                 firstOp, secondOp;
  logic [ADDR_W-1:0]      firstAddr, secondAddr;
  logic [DATA_W-1:0]      firstData, secondData;
  logic [1:0]             rspValid;
  logic [1:0][DATA_W-1:0] rspData;

  llsc_arbiter #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_arb (
    .clk(clk), .rst(rst),
    .reqValid0(reqValid0), .reqOp0(memOp_e'(reqOp0)),
    .reqAddr0(reqAddr0), .reqData0(reqData0),
    .reqValid1(reqValid1), .reqOp1(memOp_e'(reqOp1)),
    .reqAddr1(reqAddr1), .reqData1(reqData1),
    .strobe(strobe),
    .firstOp(firstOp), .firstAddr(firstAddr), .firstData(firstData),
    .secondOp(secondOp), .secondAddr(secondAddr), .secondData(secondData)
  );

  llsc_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_core (
    .clk(clk), .rst(rst), .strobe(strobe),
    .firstOp(firstOp), .firstAddr(firstAddr), .firstData(firstData),
    .secondOp(secondOp), .secondAddr(secondAddr), .secondData(secondData),
    .rspValid(rspValid), .rspData(rspData)
  );

  assign rspValid0 = rspValid[0];
  assign rspValid1 = rspValid[1];
  assign rspData0  = rspData[0];
  assign rspData1  = rspData[1];

endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid0,
  input logic [1:0]        reqOp0,
  input logic              reqValid1,
  input logic [ADDR_W-1:0] reqAddr0,
  input logic              rspValid0,
  input logic [DATA_W-1:0] rspData0,
  input logic              rspValid1
);

  localparam logic [1:0] OPC_STORE = 2'd1;
  localparam logic [1:0] OPC_COND  = 2'd3;

  assert_p0_latency_R9: assert property (@(posedge clk) disable iff (rst)
    rspValid0 == $past(reqValid0));

  assert_p1_source_R9: assert property (@(posedge clk) disable iff (rst)
    rspValid1 |-> ($past(reqValid1) || $past(reqValid1, 2)));

  assert_collide_defer_R9: assert property (@(posedge clk) disable iff (rst)
    $past(reqValid0 && reqValid1) |=> rspValid1);

  assert_store_rsp_zero_R1: assert property (@(posedge clk) disable iff (rst)
    $past(reqValid0 && reqOp0 == OPC_STORE) |-> rspData0 == '0);

  assert_cond_flag_R3: assert property (@(posedge clk) disable iff (rst)
    $past(reqValid0 && reqOp0 == OPC_COND) |-> rspData0[DATA_W-1:1] == '0);

  assert_cond_twice_fails_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(reqValid0 && reqOp0 == OPC_COND) && reqValid0 && reqOp0 == OPC_COND)
    |=> rspData0 == '0);

  // reqAddr0 is connected so the checker sees the full port-0 request.
  logic unusedAddr;
  assign unusedAddr = ^reqAddr0;

endmodule

bind llsc_monitor llsc_monitor_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst),
  .reqValid0(reqValid0), .reqOp0(reqOp0), .reqValid1(reqValid1),
  .reqAddr0(reqAddr0),
  .rspValid0(rspValid0), .rspData0(rspData0), .rspValid1(rspValid1)
);

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int RAND_STEPS = 3000;

  logic              clk = 1'b0;
  logic              rst;
  logic              reqValid0, reqValid1;
  logic [1:0]        reqOp0, reqOp1;
  logic [ADDR_W-1:0] reqAddr0, reqAddr1;
  logic [DATA_W-1:0] reqData0, reqData1;
  logic              rspValid0, rspValid1;
  logic [DATA_W-1:0] rspData0, rspData1;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // bench model
  logic [DATA_W-1:0] mMem [DEPTH];
  bit                mResV [2];
  int                mResA [2];
  bit                mParkV;
  int                mParkOp, mParkA;
  logic [DATA_W-1:0] mParkD;

  always #(CLK_PERIOD/2) clk = ~clk;

  llsc_monitor #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst),
    .reqValid0(reqValid0), .reqOp0(reqOp0), .reqAddr0(reqAddr0), .reqData0(reqData0),
    .reqValid1(reqValid1), .reqOp1(reqOp1), .reqAddr1(reqAddr1), .reqData1(reqData1),
    .rspValid0(rspValid0), .rspData0(rspData0),
    .rspValid1(rspValid1), .rspData1(rspData1)
  );

  task automatic chk(input bit ok, input string tag, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Applies one request to the model following R1..R8.
  task automatic modelOp(input int p, input int op, input int a,
                         input logic [DATA_W-1:0] d, output logic [DATA_W-1:0] r);
    bit commit = 0;
    r = '0;
    case (op)
      0: r = mMem[a];
      1: commit = 1;
      2: begin r = mMem[a]; mResV[p] = 1; mResA[p] = a; end
      default: begin
        commit = mResV[p] && mResA[p] == a;
        mResV[p] = 0;
        r = DATA_W'(commit);
      end
    endcase
    if (commit) begin
      mMem[a] = d;
      if (mResV[1-p] && mResA[1-p] == a) mResV[1-p] = 0;
    end
  endtask

  // Drives one cycle (called at a negedge), predicts per R9, checks at next negedge.
  task automatic step(input bit v0, input int o0, input int a0, input logic [DATA_W-1:0] d0,
                      input bit v1, input int o1, input int a1, input logic [DATA_W-1:0] d1,
                      input string tag);
    bit eV0 = 0, eV1 = 0, now1, park;
    logic [DATA_W-1:0] eD0 = '0, eD1 = '0, r;
    reqValid0 = v0; reqOp0 = 2'(o0); reqAddr0 = ADDR_W'(a0); reqData0 = d0;
    reqValid1 = v1; reqOp1 = 2'(o1); reqAddr1 = ADDR_W'(a1); reqData1 = d1;
    now1 = v1 && !v0 && !mParkV;
    park = v1 && !now1;
    if (mParkV) begin modelOp(1, mParkOp, mParkA, mParkD, r); eV1 = 1; eD1 = r; end
    if (v0) begin modelOp(0, o0, a0, d0, r); eV0 = 1; eD0 = r; end
    else if (now1) begin modelOp(1, o1, a1, d1, r); eV1 = 1; eD1 = r; end
    mParkV = park; mParkOp = o1; mParkA = a1; mParkD = d1;
    @(negedge clk);
    chk(rspValid0 == eV0 && (!eV0 || rspData0 == eD0), {tag, " port0"},
        {rspValid0, rspData0[DATA_W-2:0]}, {eV0, eD0[DATA_W-2:0]});
    chk(rspValid1 == eV1 && (!eV1 || rspData1 == eD1), {tag, " port1"},
        {rspValid1, rspData1[DATA_W-2:0]}, {eV1, eD1[DATA_W-2:0]});
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, '0, 0, 0, 0, '0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int w = 0; w < DEPTH; w++) mMem[w] = '0;
    mResV[0] = 0; mResV[1] = 0; mResA[0] = 0; mResA[1] = 0; mParkV = 0;
    rst = 1'b1;
    reqValid0 = 0; reqValid1 = 0; reqOp0 = 0; reqOp1 = 0;
    reqAddr0 = 0; reqAddr1 = 0; reqData0 = 0; reqData1 = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!rspValid0 && !rspValid1, "R10 response valids after reset",
        {rspValid0, rspValid1}, 0);

    // R10: memory reads back zero
    for (int a = 0; a < 4; a++) begin
      step(1, 0, a, '0, 0, 0, 0, '0, "R10 zero memory");
      chk(rspData0 == 0, "R10 explicit zero", rspData0, 0);
    end
    // R4: port1 conditional write with no reservation since reset
    step(0, 0, 0, '0, 1, 3, 2, 32'hdead, "R4 cond without reservation");
    chk(rspData1 == 0, "R4 explicit flag", rspData1, 0);
    step(1, 0, 2, '0, 0, 0, 0, '0, "R4 memory untouched");
    chk(rspData0 == 0, "R4 explicit read", rspData0, 0);
    // R1
    step(1, 1, 2, 32'h55, 0, 0, 0, '0, "R1 plain write");
    step(1, 0, 2, '0, 0, 0, 0, '0, "R1 plain read");
    chk(rspData0 == 32'h55, "R1 explicit read", rspData0, 32'h55);
    // R2 + R3
    step(1, 2, 1, '0, 0, 0, 0, '0, "R2 linked read");
    step(1, 3, 1, 32'h77, 0, 0, 0, '0, "R3 cond success");
    chk(rspData0 == 1, "R3 explicit flag", rspData0, 1);
    step(1, 0, 1, '0, 0, 0, 0, '0, "R3 written value");
    chk(rspData0 == 32'h77, "R3 explicit read", rspData0, 32'h77);
    // R6: second conditional without new link
    step(1, 3, 1, 32'h99, 0, 0, 0, '0, "R6 repeat cond fails");
    chk(rspData0 == 0, "R6 explicit flag", rspData0, 0);
    // R5: other port writes reserved word
    step(1, 2, 3, '0, 0, 0, 0, '0, "R5 link");
    step(0, 0, 0, '0, 1, 1, 3, 32'h11, "R5 other-port write");
    step(1, 3, 3, 32'h22, 0, 0, 0, '0, "R5 cond after conflict");
    chk(rspData0 == 0, "R5 explicit flag broken", rspData0, 0);
    // R5: other port writes a different word
    step(1, 2, 3, '0, 0, 0, 0, '0, "R5 relink");
    step(0, 0, 0, '0, 1, 1, 2, 32'h33, "R5 write other word");
    step(1, 3, 3, 32'h44, 0, 0, 0, '0, "R5 cond intact");
    chk(rspData0 == 1, "R5 explicit flag intact", rspData0, 1);
    // R7
    step(1, 2, 1, '0, 0, 0, 0, '0, "R7 first link");
    step(1, 2, 0, '0, 0, 0, 0, '0, "R7 replacing link");
    step(1, 3, 1, 32'h66, 0, 0, 0, '0, "R7 cond to old word");
    chk(rspData0 == 0, "R7 explicit flag", rspData0, 0);
    // R8
    step(1, 2, 1, '0, 0, 0, 0, '0, "R8 link");
    step(1, 3, 2, 32'h88, 0, 0, 0, '0, "R8 cond wrong word");
    chk(rspData0 == 0, "R8 explicit flag", rspData0, 0);
    step(1, 0, 2, '0, 0, 0, 0, '0, "R8 word unchanged");
    chk(rspData0 == 32'h33, "R8 explicit read", rspData0, 32'h33);
    // R9: same-cycle race on word 0
    step(1, 2, 0, '0, 1, 2, 0, '0, "R9 both link");
    chk(!rspValid1, "R9 port1 parked", rspValid1, 0);
    idle("R9 parked link drains");
    step(1, 3, 0, 32'haa, 1, 3, 0, 32'hbb, "R9 both cond");
    chk(rspData0 == 1, "R9 port0 wins", rspData0, 1);
    idle("R9 parked cond drains");
    chk(rspValid1 && rspData1 == 0, "R9 port1 loses", rspData1, 0);
    step(0, 0, 0, '0, 1, 0, 0, '0, "R9 lone port1 read");
    chk(rspData1 == 32'haa, "R9 explicit final word", rspData1, 32'haa);

    // constrained random traffic on four words
    for (int i = 0; i < RAND_STEPS; i++) begin
      step(($urandom % 3) != 0, int'($urandom % 4), int'($urandom % 4), $urandom,
           ($urandom % 3) != 0, int'($urandom % 4), int'($urandom % 4), $urandom,
           "R1 R2 R3 R5 R9 random");
    end
    idle("R9 final drain");

    done = 1'b1;
    report();
    $finish;
  end

endmodule